// File: doc/BRIEF.md
# Loopback Stream Receive Engine

This block is the receive half of a packet DMA whose transmit stream output is tied straight back into its own receive stream input. Each packet that leaves the transmit side arrives here at once and is placed into memory for another core to pick up. This makes the loopback path a transport for transfers between cores.

For every packet the engine reads a flow number from a sideband field on the first beat. It looks that number up in a small configured table to find a free-descriptor queue and a destination queue. It pops one descriptor from the free queue, with a retry whenever the queue manager answers with a null address. It then writes the packet words into the buffer area that follows the descriptor header. When the packet is done it writes a header word with the byte count and an overflow flag, and pushes the descriptor address onto the destination queue. The consuming core must later return the descriptor to a free queue; the engine never recycles descriptors on its own.

All data and queue interfaces use valid/ready style handshakes. On the input stream, `lb_ready` is low while the engine is idle, while it is fetching a descriptor, and while it writes the header or pushes. While data is being stored, `lb_ready` follows `mem_wready`, so a stalled memory stalls the sender. The memory write port and the push port keep their request and payload steady until the other side accepts them. The flow table inputs are plain configuration levels.

Top module: `lbk_rx_engine`

## Requirements
- R1: After reset, `pop_req`, `push_valid`, `mem_wvalid` and `lb_ready` are all low.
- R2: The flow number on `lb_flow` during the first beat selects the table entry. `pop_qnum` equals that flow's free-queue field, where flow f occupies bits [f*QNUM_W +: QNUM_W] of `cfg_free_q`.
- R3: A pop answered with address 0 is a null result. The engine keeps `pop_req` high and retries, with `lb_ready` and `mem_wvalid` low, until a non-zero address arrives.
- R4: Beat i of a packet (counting from 0) is written to byte address desc + BYTES*(i+1), where desc is the popped address and BYTES = DATA_W/8.
- R5: A beat is consumed only on `lb_valid && lb_ready`. While the buffer has room, `lb_ready` equals `mem_wready`, so each stored beat gives exactly one memory write.
- R6: After the beat that carries `lb_last` is accepted, one header word is written at address desc. Bit 31 is the overflow flag, bits [15:0] hold the stored byte count, and all other bits are zero. This write is accepted before the push begins.
- R7: The push carries `push_addr` = desc and `push_qnum` = the flow's destination field, taken from `cfg_dest_q` at the same bit positions as in R2.
- R8: If a packet has more than BUF_BYTES/BYTES beats, the extra beats are accepted and dropped without a memory write. The header then has bit 31 set and a byte count of BUF_BYTES.
- R9: Each packet produces exactly one accepted pop with a non-zero address and exactly one accepted push. No new pop starts while a push is pending.
- R10: While `push_valid` is high and `push_ready` is low, `push_valid`, `push_addr` and `push_qnum` stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_free_q | input | NUM_FLOWS*QNUM_W | Free-queue number per flow |
| cfg_dest_q | input | NUM_FLOWS*QNUM_W | Destination-queue number per flow |
| lb_valid | input | 1 | Loopback stream beat valid |
| lb_ready | output | 1 | Loopback stream beat accepted |
| lb_data | input | DATA_W | Beat payload |
| lb_last | input | 1 | Final beat of packet |
| lb_flow | input | FLOW_W | Flow number, sampled on first beat |
| pop_req | output | 1 | Free-queue pop request |
| pop_qnum | output | QNUM_W | Queue to pop |
| pop_ack | input | 1 | Pop answered this cycle |
| pop_addr | input | ADDR_W | Popped descriptor address, 0 when empty |
| mem_wvalid | output | 1 | Memory write request |
| mem_wready | input | 1 | Memory write accepted |
| mem_waddr | output | ADDR_W | Byte address of write |
| mem_wdata | output | DATA_W | Write data |
| push_valid | output | 1 | Completed descriptor push request |
| push_ready | input | 1 | Push accepted |
| push_qnum | output | QNUM_W | Destination queue |
| push_addr | output | ADDR_W | Descriptor address pushed |

## Verification
The pop answer is used at the clock edge that samples `pop_ack`. A beat write happens in the same cycle the beat is offered, because `lb_ready` passes `mem_wready` through without a register. The header write follows one cycle after the last beat is accepted, and the push follows one cycle after the header is accepted. The bench drives every input on the falling edge and reads the combinational handshakes 1 ns later, so the transfer it records is exactly the one the next rising edge commits. Per-packet results (memory words, header, pop and push contents) are compared only after the push handshake has been seen. Because these checks wait for a completed packet rather than a fixed cycle count, stalls on memory, push and null pops cannot shift where a result is sampled.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_FILL,
    ST_HDR,
    ST_PUSH
  } rx_state_t;
endpackage

// File: rtl/lbk_flow_sel.sv
module lbk_flow_sel #(
  parameter int NUM_FLOWS = 4,
  parameter int QNUM_W    = 4,
  parameter int FLOW_W    = 2
) (
  input  logic [NUM_FLOWS*QNUM_W-1:0] free_tbl,
  input  logic [NUM_FLOWS*QNUM_W-1:0] dest_tbl,
  input  logic [FLOW_W-1:0]           flow,
  output logic [QNUM_W-1:0]           free_q,
  output logic [QNUM_W-1:0]           dest_q
);
  logic [QNUM_W-1:0] free_arr [NUM_FLOWS];
  logic [QNUM_W-1:0] dest_arr [NUM_FLOWS];

  for (genvar g = 0; g < NUM_FLOWS; g++) begin : g_unpack
    assign free_arr[g] = free_tbl[g*QNUM_W +: QNUM_W];
    assign dest_arr[g] = dest_tbl[g*QNUM_W +: QNUM_W];
  end

  always_comb begin
    free_q = '0;
    dest_q = '0;
    for (int i = 0; i < NUM_FLOWS; i++) begin
      if (FLOW_W'(i) == flow) begin
        free_q = free_arr[i];
        dest_q = dest_arr[i];
      end
    end
  end
endmodule

// File: rtl/lbk_fill_ctr.sv
module lbk_fill_ctr #(
  parameter int MAX_BEATS = 4,
  parameter int CNT_W     = $clog2(MAX_BEATS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             full,
  output logic             ovf
);
  assign full = (cnt == CNT_W'(MAX_BEATS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (clear) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (step) begin
      if (full) ovf <= 1'b1;
      else      cnt <= cnt + 1'b1;
    end
  end

  // Stored beats never pass the buffer capacity (R8)
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_BEATS));

  // Overflow is only raised by a beat that arrives with the buffer full (R8)
  assert_ovf_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf && !clear && step && !full) |=> !ovf);
endmodule

// File: rtl/lbk_rx_engine.sv
module lbk_rx_engine
  import lbk_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 16,
  parameter int QNUM_W    = 4,
  parameter int FLOW_W    = 2,
  parameter int NUM_FLOWS = 4,
  parameter int BUF_BYTES = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_FLOWS*QNUM_W-1:0] cfg_free_q,
  input  logic [NUM_FLOWS*QNUM_W-1:0] cfg_dest_q,
  input  logic                        lb_valid,
  output logic                        lb_ready,
  input  logic [DATA_W-1:0]           lb_data,
  input  logic                        lb_last,
  input  logic [FLOW_W-1:0]           lb_flow,
  output logic                        pop_req,
  output logic [QNUM_W-1:0]           pop_qnum,
  input  logic                        pop_ack,
  input  logic [ADDR_W-1:0]           pop_addr,
  output logic                        mem_wvalid,
  input  logic                        mem_wready,
  output logic [ADDR_W-1:0]           mem_waddr,
  output logic [DATA_W-1:0]           mem_wdata,
  output logic                        push_valid,
  input  logic                        push_ready,
  output logic [QNUM_W-1:0]           push_qnum,
  output logic [ADDR_W-1:0]           push_addr
);
  localparam int BYTES     = DATA_W / 8;
  localparam int MAX_BEATS = BUF_BYTES / BYTES;
  localparam int CNT_W     = $clog2(MAX_BEATS + 1);
  localparam int LEN_W     = 16;

  rx_state_t         state;
  logic [FLOW_W-1:0] flow_q;
  logic [ADDR_W-1:0] desc_q;
  logic [QNUM_W-1:0] free_q, dest_q;
  logic [CNT_W-1:0]  cnt;
  logic              full, ovf, step;
  logic [LEN_W-1:0]  len;
  logic [DATA_W-1:0] hdr_word;

  lbk_flow_sel #(.NUM_FLOWS(NUM_FLOWS), .QNUM_W(QNUM_W), .FLOW_W(FLOW_W)) i_sel (
    .free_tbl (cfg_free_q),
    .dest_tbl (cfg_dest_q),
    .flow     (flow_q),
    .free_q   (free_q),
    .dest_q   (dest_q)
  );

  lbk_fill_ctr #(.MAX_BEATS(MAX_BEATS), .CNT_W(CNT_W)) i_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (state == ST_IDLE),
    .step  (step),
    .cnt   (cnt),
    .full  (full),
    .ovf   (ovf)
  );

  assign lb_ready = (state == ST_FILL) && (full || mem_wready);
  assign step     = lb_valid && lb_ready;

  assign pop_req  = (state == ST_FETCH);
  assign pop_qnum = free_q;

  assign len      = LEN_W'(32'(cnt) * BYTES);
  assign hdr_word = {ovf, {(DATA_W-1-LEN_W){1'b0}}, len};

  assign mem_wvalid = (state == ST_HDR) || ((state == ST_FILL) && lb_valid && !full);
  assign mem_waddr  = (state == ST_HDR) ? desc_q
                                        : desc_q + ADDR_W'((32'(cnt) + 1) * BYTES);
  assign mem_wdata  = (state == ST_HDR) ? hdr_word : lb_data;

  assign push_valid = (state == ST_PUSH);
  assign push_qnum  = dest_q;
  assign push_addr  = desc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      flow_q <= '0;
      desc_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (lb_valid) begin
          flow_q <= lb_flow;
          state  <= ST_FETCH;
        end
        ST_FETCH: if (pop_ack && (pop_addr != '0)) begin
          desc_q <= pop_addr;
          state  <= ST_FILL;
        end
        ST_FILL:  if (step && lb_last) state <= ST_HDR;
        ST_HDR:   if (mem_wready) state <= ST_PUSH;
        ST_PUSH:  if (push_ready) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // Nothing moves on stream or memory while a descriptor is pending (R3)
  assert_fetch_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req |-> (!lb_ready && !mem_wvalid));

  // A null answer keeps the request up on the next cycle (R3)
  assert_null_retry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && pop_ack && pop_addr == '0) |=> pop_req);

  // Stream beats are taken only in the fill phase (R5)
  assert_ready_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lb_ready |-> !pop_req && !push_valid);

  // Data writes stay inside the buffer after the header (R8)
  assert_buf_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FILL && mem_wvalid) |->
      ((mem_waddr - desc_q) >= ADDR_W'(BYTES) && (mem_waddr - desc_q) <= ADDR_W'(BUF_BYTES)));

  // Pop and push never overlap (R9)
  assert_pop_push_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_req && push_valid));

  // Pending push holds steady (R10)
  assert_push_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> (push_valid && $stable(push_addr) && $stable(push_qnum)));
endmodule

// File: tb/test_lbk_rx_engine.sv
module test_lbk_rx_engine;
  localparam int DATA_W = 32, ADDR_W = 16, QNUM_W = 4, FLOW_W = 2, NF = 4, BUFB = 16;
  localparam int MAXB = BUFB / 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NF*QNUM_W-1:0] cfg_free_q, cfg_dest_q;
  logic lb_valid = 1'b0, lb_ready, lb_last = 1'b0;
  logic [DATA_W-1:0] lb_data = '0;
  logic [FLOW_W-1:0] lb_flow = '0;
  logic pop_req, pop_ack = 1'b0;
  logic [QNUM_W-1:0] pop_qnum, push_qnum;
  logic [ADDR_W-1:0] pop_addr = '0, mem_waddr, push_addr;
  logic mem_wvalid, mem_wready = 1'b0;
  logic [DATA_W-1:0] mem_wdata;
  logic push_valid, push_ready = 1'b0;

  always #10 clk = ~clk;

  lbk_rx_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .QNUM_W(QNUM_W), .FLOW_W(FLOW_W),
                  .NUM_FLOWS(NF), .BUF_BYTES(BUFB)) i_lbk_rx_engine (
    .clk(clk), .rst_n(rst_n), .cfg_free_q(cfg_free_q), .cfg_dest_q(cfg_dest_q),
    .lb_valid(lb_valid), .lb_ready(lb_ready), .lb_data(lb_data), .lb_last(lb_last),
    .lb_flow(lb_flow), .pop_req(pop_req), .pop_qnum(pop_qnum), .pop_ack(pop_ack),
    .pop_addr(pop_addr), .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .push_valid(push_valid),
    .push_ready(push_ready), .push_qnum(push_qnum), .push_addr(push_addr));

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] mem [256];
  int nulls_left = 0, pops_seen = 0, good_pops = 0, writes_seen = 0, pushes_seen = 0;
  int quiet_viol = 0, hold_viol = 0;
  logic [QNUM_W-1:0] seen_pop_q, seen_push_q;
  logic [ADDR_W-1:0] seen_push_a, cur_desc = '0;
  logic pend_push = 1'b0;
  logic [ADDR_W-1:0] pend_a;
  logic done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // queue manager model: answer every request, nulls first when asked
  initial forever begin
    @(negedge clk); pop_ack = 1'b0;
    #1;
    if (rst_n && pop_req) begin
      pop_ack = 1'b1; pops_seen++; seen_pop_q = pop_qnum;
      if (nulls_left > 0) begin pop_addr = '0; nulls_left--; end
      else begin pop_addr = cur_desc; good_pops++; end
    end
  end

  // memory model with a stall pattern
  initial forever begin
    @(negedge clk); mem_wready = (cyc % 4) != 1;
    #1;
    if (rst_n && mem_wvalid && mem_wready) begin
      mem[mem_waddr[9:2]] = mem_wdata; writes_seen++;
    end
    if (rst_n && pop_req && (lb_ready || mem_wvalid)) quiet_viol++;
  end

  // push sink with a stall pattern and hold monitor
  initial forever begin
    @(negedge clk); push_ready = (cyc % 3) == 0;
    #1;
    if (pend_push && !(push_valid && push_addr == pend_a)) hold_viol++;
    pend_push = 1'b0;
    if (rst_n && push_valid) begin
      if (push_ready) begin
        pushes_seen++; seen_push_q = push_qnum; seen_push_a = push_addr;
      end else begin
        pend_push = 1'b1; pend_a = push_addr;
      end
    end
  end

  task automatic send_pkt(input int f, input int n, input int pk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lb_valid = 1'b1; lb_flow = FLOW_W'(f); lb_last = (i == n - 1);
      lb_data = 32'hA500_0000 | (pk << 8) | i;
      #1;
      while (!lb_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk); lb_valid = 1'b0; lb_last = 1'b0;
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < NF; f++) begin
      cfg_free_q[f*QNUM_W +: QNUM_W] = QNUM_W'(4 + f);
      cfg_dest_q[f*QNUM_W +: QNUM_W] = QNUM_W'(11 - f);
    end
    repeat (3) @(negedge clk);
    #2;
    chk("R1 pop_req", {31'd0, pop_req}, 0);
    chk("R1 push_valid", {31'd0, push_valid}, 0);
    chk("R1 mem_wvalid", {31'd0, mem_wvalid}, 0);
    chk("R1 lb_ready", {31'd0, lb_ready}, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int f = 0; f < NF; f++) begin
      for (int n = 1; n <= 6; n++) begin
        int pk, slot, stored, p0, gp0, w0, q0;
        logic [31:0] exp_hdr;
        pk = f * 6 + n;
        slot = pk;
        cur_desc = ADDR_W'(slot * 32);
        for (int w = 0; w < 8; w++) mem[slot*8 + w] = 32'hDEAD_BEEF;
        nulls_left = f;
        p0 = pops_seen; gp0 = good_pops; w0 = writes_seen; q0 = pushes_seen;
        send_pkt(f, n, pk);
        while (pushes_seen == q0) @(negedge clk);
        @(negedge clk);
        stored = (n > MAXB) ? MAXB : n;
        exp_hdr = {(n > MAXB), 15'd0, 16'(stored * 4)};
        chk("R2 pop queue", {28'd0, seen_pop_q}, 4 + f);
        chk("R3 pop attempts", pops_seen - p0, f + 1);
        for (int i = 0; i < stored; i++)
          chk("R4 data word", mem[slot*8 + 1 + i], 32'hA500_0000 | (pk << 8) | i);
        chk("R5 write count", writes_seen - w0, stored + 1);
        chk("R6 header", mem[slot*8], exp_hdr);
        chk("R7 push queue", {28'd0, seen_push_q}, 11 - f);
        chk("R7 push addr", {16'd0, seen_push_a}, {16'd0, cur_desc});
        for (int i = stored; i < 7; i++)
          chk("R8 untouched word", mem[slot*8 + 1 + i], 32'hDEAD_BEEF);
        chk("R8 overflow flag", {31'd0, mem[slot*8][31]}, (n > MAXB) ? 1 : 0);
        chk("R9 one pop", good_pops - gp0, 1);
        chk("R9 one push", pushes_seen - q0, 1);
      end
    end
    chk("R3 quiet during fetch", quiet_viol, 0);
    chk("R10 push hold", hold_viol, 0);
    chk("R1 idle after sweep", {30'd0, push_valid, pop_req}, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule